// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor core and the devices that share its 16-bit address space. Each bus cycle it decodes the address. It raises exactly one chip select, or none, and gives the selected peripheral its local register index. It also supplies the data for reads that the block answers itself.

The block holds a small on-chip I/O port: a direction register at address 0 and a data register at address 1. The low three bits of the effective port value, (NOT direction) OR data, form the bank configuration. That configuration decides whether the upper regions show ROM images, character ROM, the I/O page or plain RAM. Writes that hit a ROM window always land in the RAM underneath.

The colour RAM window is four bits wide. Its upper read nibble is taken from the last byte seen on the bus. Unused parts of the I/O page read back that same floating byte. The block contains no memory or peripheral contents; it only steers accesses to them.

Top module: `bank_map_top`

## Requirements
- R1: After reset both port registers are 0, so the configuration reads as 3'b111. A read of address 0 returns 0x00 and a read of address 1 returns 0x17.
- R2: A write (bus_en=1, bus_wr=1) to address 0 loads the direction register, and a write to address 1 loads the data register, both from wdata on that clock edge. During the write sel is RAM (bit 0) and wr_data equals float_byte. Idle or read cycles leave both registers unchanged.
- R3: A read of address 0 or 1 selects nothing and sets rd_local=1. rd_data is the direction register for address 0, and (dir AND data) OR (NOT dir AND 0x17) for address 1.
- R4: The configuration is cfg = ((NOT dir) OR data)[2:0]. A read in 0xA000–0xBFFF selects BASIC ROM (bit 1) when cfg[1:0]==2'b11, otherwise RAM (bit 0).
- R5: A read in 0xE000–0xFFFF selects KERNAL ROM (bit 2) when cfg[1]=1, otherwise RAM.
- R6: In 0xD000–0xDFFF the I/O page is mapped when cfg[1:0]!=0 and cfg[2]=1. Character ROM (bit 3) is mapped on reads when cfg[1:0]!=0 and cfg[2]=0. Otherwise the access goes to RAM.
- R7: With I/O mapped, the block decodes these ranges. 0xD000–0xD3FF selects video (bit 4, index addr[5:0]). 0xD400–0xD7FF selects sound (bit 5, index addr[4:0]). 0xDC00–0xDCFF selects timer 1 (bit 7, index addr[3:0]). 0xDD00–0xDDFF selects timer 2 (bit 8, index addr[3:0]). 0xDF00–0xDF0F selects expansion (bit 9, index addr[3:0]). All other accesses give reg_idx 0.
- R8: With I/O mapped, 0xD800–0xDBFF selects colour RAM (bit 6, index addr[9:0]). On a write, wr_data={4'h0, wdata[3:0]}. On a read, rd_local=1 and rd_data={float_byte[7:4], cram_nib}.
- R9: With I/O mapped, reads in 0xDE00–0xDFFF outside 0xDF00–0xDF0F select nothing and return float_byte with rd_local=1. Writes there select nothing.
- R10: Writes to 0xA000–0xBFFF, 0xE000–0xFFFF, and to 0xD000–0xDFFF when I/O is not mapped, select RAM with wr_data=wdata, whatever the ROM mapping.
- R11: sel has at most one bit set. With bus_en=0, sel is 0 and rd_local is 0.
- R12: Accesses to 0x0002–0x9FFF and 0xC000–0xCFFF select RAM. Writes there carry wr_data=wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| float_byte | input | 8 | Last byte seen on the bus |
| cram_nib | input | 4 | Nibble read from colour RAM |
| sel | output | 10 | One-hot chip select (bit map in R2–R9) |
| reg_idx | output | 10 | Local register index for the selected peripheral |
| wr_data | output | 8 | Data presented to the selected target on writes |
| rd_local | output | 1 | rd_data is valid and answers this read |
| rd_data | output | 8 | Read data produced inside the block |

## Verification
The assertions take bus_en, bus_wr and addr to be stable for the whole cycle. They check the registered port state only from one edge to the next, so they assume no access other than the one decoded in that same cycle. The stimulus changes every input only at the falling edge and keeps each access alive for a single cycle. Random addresses are weighted so that every region, and port writes of every configuration, appear often.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int NUM_SEL = 10;
    localparam int S_RAM    = 0;
    localparam int S_BASIC  = 1;
    localparam int S_KERNAL = 2;
    localparam int S_CHAR   = 3;
    localparam int S_VIDEO  = 4;
    localparam int S_SOUND  = 5;
    localparam int S_COLOR  = 6;
    localparam int S_TMR1   = 7;
    localparam int S_TMR2   = 8;
    localparam int S_EXP    = 9;

    typedef enum logic [1:0] {
        RS_NONE  = 2'd0,
        RS_PORT  = 2'd1,
        RS_COLOR = 2'd2,
        RS_FLOAT = 2'd3
    } rd_src_e;
endpackage

// File: rtl/bank_port_regs.sv
module bank_port_regs #(
    parameter int DW        = 8,
    parameter int CFG_W     = 3,
    parameter logic [DW-1:0] PULL_MASK = 8'h17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_dir,
    input  logic             ld_dat,
    input  logic             rd_sel,
    input  logic [DW-1:0]    wdata,
    output logic [CFG_W-1:0] cfg,
    output logic [DW-1:0]    port_rd
);
    logic [DW-1:0] dir_q;
    logic [DW-1:0] dat_q;
    logic [DW-1:0] eff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else begin
            if (ld_dir) dir_q <= wdata;
            if (ld_dat) dat_q <= wdata;
        end
    end

    always_comb begin
        eff     = ~dir_q | dat_q;
        cfg     = eff[CFG_W-1:0];
        port_rd = rd_sel ? ((dir_q & dat_q) | (~dir_q & PULL_MASK)) : dir_q;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dir |=> (dir_q == $past(wdata))); // R2
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_dir && !ld_dat) |=> ($stable(dir_q) && $stable(dat_q))); // R2
endmodule

// File: rtl/bank_decode.sv
module bank_decode
    import bank_map_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 10,
    parameter int CFG_W = 3
) (
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [AW-1:0]      addr,
    input  logic [CFG_W-1:0]   cfg,
    output logic [NUM_SEL-1:0] sel,
    output logic [IDX_W-1:0]   reg_idx,
    output rd_src_e            rd_src,
    output logic               port_wr,
    output logic               cram_wr
);
    localparam int TOP = AW - 1;

    logic basic_on, kernal_on, io_on, char_on;

    always_comb begin
        basic_on  = (cfg[1:0] == 2'b11);
        kernal_on = cfg[1];
        io_on     = (cfg[1:0] != 2'b00) && cfg[2];
        char_on   = (cfg[1:0] != 2'b00) && !cfg[2];
    end

    always_comb begin
        sel     = '0;
        reg_idx = '0;
        rd_src  = RS_NONE;
        port_wr = 1'b0;
        cram_wr = 1'b0;
        if (bus_en) begin
            if (addr[TOP:1] == '0) begin
                if (bus_wr) begin
                    sel[S_RAM] = 1'b1;
                    port_wr    = 1'b1;
                end else begin
                    rd_src = RS_PORT;
                end
            end else begin
                unique case (addr[TOP:TOP-3])
                    4'hA, 4'hB: begin
                        if (!bus_wr && basic_on) sel[S_BASIC] = 1'b1;
                        else                     sel[S_RAM]   = 1'b1;
                    end
                    4'hE, 4'hF: begin
                        if (!bus_wr && kernal_on) sel[S_KERNAL] = 1'b1;
                        else                      sel[S_RAM]    = 1'b1;
                    end
                    4'hD: begin
                        if (io_on) begin
                            unique case (addr[11:8])
                                4'h0, 4'h1, 4'h2, 4'h3: begin
                                    sel[S_VIDEO] = 1'b1;
                                    reg_idx      = IDX_W'(addr[5:0]);
                                end
                                4'h4, 4'h5, 4'h6, 4'h7: begin
                                    sel[S_SOUND] = 1'b1;
                                    reg_idx      = IDX_W'(addr[4:0]);
                                end
                                4'h8, 4'h9, 4'hA, 4'hB: begin
                                    sel[S_COLOR] = 1'b1;
                                    reg_idx      = IDX_W'(addr[9:0]);
                                    if (bus_wr) cram_wr = 1'b1;
                                    else        rd_src  = RS_COLOR;
                                end
                                4'hC: begin
                                    sel[S_TMR1] = 1'b1;
                                    reg_idx     = IDX_W'(addr[3:0]);
                                end
                                4'hD: begin
                                    sel[S_TMR2] = 1'b1;
                                    reg_idx     = IDX_W'(addr[3:0]);
                                end
                                default: begin
                                    if (addr[11:4] == 8'hF0) begin
                                        sel[S_EXP] = 1'b1;
                                        reg_idx    = IDX_W'(addr[3:0]);
                                    end else if (!bus_wr) begin
                                        rd_src = RS_FLOAT;
                                    end
                                end
                            endcase
                        end else if (char_on && !bus_wr) begin
                            sel[S_CHAR] = 1'b1;
                        end else begin
                            sel[S_RAM] = 1'b1;
                        end
                    end
                    default: sel[S_RAM] = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/bank_map_top.sv
module bank_map_top
    import bank_map_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int IDX_W = 10,
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [DW-1:0]      float_byte,
    input  logic [NIB_W-1:0]   cram_nib,
    output logic [NUM_SEL-1:0] sel,
    output logic [IDX_W-1:0]   reg_idx,
    output logic [DW-1:0]      wr_data,
    output logic               rd_local,
    output logic [DW-1:0]      rd_data
);
    localparam int CFG_W = 3;

    logic [CFG_W-1:0] cfg;
    logic [DW-1:0]    port_rd;
    rd_src_e          rd_src;
    logic             port_wr, cram_wr;

    bank_port_regs #(.DW(DW), .CFG_W(CFG_W)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_dir (port_wr && !addr[0]),
        .ld_dat (port_wr && addr[0]),
        .rd_sel (addr[0]),
        .wdata  (wdata),
        .cfg    (cfg),
        .port_rd(port_rd)
    );

    bank_decode #(.AW(AW), .IDX_W(IDX_W), .CFG_W(CFG_W)) u_dec (
        .bus_en (bus_en),
        .bus_wr (bus_wr),
        .addr   (addr),
        .cfg    (cfg),
        .sel    (sel),
        .reg_idx(reg_idx),
        .rd_src (rd_src),
        .port_wr(port_wr),
        .cram_wr(cram_wr)
    );

    always_comb begin
        if (port_wr)      wr_data = float_byte;
        else if (cram_wr) wr_data = {{(DW-NIB_W){1'b0}}, wdata[NIB_W-1:0]};
        else              wr_data = wdata;
    end

    always_comb begin
        rd_local = (rd_src != RS_NONE);
        unique case (rd_src)
            RS_PORT:  rd_data = port_rd;
            RS_COLOR: rd_data = {float_byte[DW-1:NIB_W], cram_nib};
            RS_FLOAT: rd_data = float_byte;
            default:  rd_data = '0;
        endcase
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (sel == '0 && !rd_local)); // R11
    AST_ROM_WRITE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && addr[15:13] == 3'b101) |-> sel[S_RAM]); // R10
    AST_KERNAL_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && addr[15:13] == 3'b111 && cfg[1]) |-> sel[S_KERNAL]); // R5
    AST_COLOR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[S_COLOR] && bus_wr) |-> (wr_data[7:4] == 4'h0)); // R8
    AST_PORT_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && addr[15:1] == '0) |-> (rd_local && sel == '0)); // R3
endmodule

// File: tb/sim_bank_map_top.sv
`timescale 1ns/1ps
module sim_bank_map_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, float_byte = '0;
    logic [3:0]  cram_nib = '0;
    logic [9:0]  sel, reg_idx;
    logic [7:0]  wr_data, rd_data;
    logic        rd_local;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_dir = 8'h00, m_dat = 8'h00;

    bank_map_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .addr(addr),
        .wdata(wdata), .float_byte(float_byte), .cram_nib(cram_nib),
        .sel(sel), .reg_idx(reg_idx), .wr_data(wr_data), .rd_local(rd_local), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [9:0] e_sel, e_idx;
    logic [7:0] e_wr, e_rd;
    logic       e_loc;
    string      tag;

    task automatic expect_calc(input logic en, input logic wr, input logic [15:0] a,
                               input logic [7:0] d, input logic [7:0] fb, input logic [3:0] nb);
        logic [2:0] c;
        logic io, ch;
        c  = (~m_dir[2:0]) | m_dat[2:0];
        io = (c[1:0] != 2'b00) && c[2];
        ch = (c[1:0] != 2'b00) && !c[2];
        e_sel = '0; e_idx = '0; e_wr = d; e_rd = '0; e_loc = 1'b0;
        tag = "R12";
        if (!en) begin
            tag = "R11";
        end else if (a < 16'h0002) begin
            if (wr) begin tag = "R2"; e_sel = 10'b1; e_wr = fb; end
            else begin
                tag = "R3"; e_loc = 1'b1;
                e_rd = a[0] ? ((m_dir & m_dat) | (~m_dir & 8'h17)) : m_dir;
            end
        end else if (a >= 16'hA000 && a < 16'hC000) begin
            tag = wr ? "R10" : "R4";
            e_sel = (!wr && c[1:0] == 2'b11) ? 10'b10 : 10'b1;
        end else if (a >= 16'hE000) begin
            tag = wr ? "R10" : "R5";
            e_sel = (!wr && c[1]) ? 10'b100 : 10'b1;
        end else if (a >= 16'hD000 && a < 16'hE000) begin
            if (!io) begin
                tag = wr ? "R10" : "R6";
                e_sel = (!wr && ch) ? 10'b1000 : 10'b1;
            end else if (a < 16'hD400) begin tag = "R7"; e_sel = 10'd1 << 4; e_idx = {4'h0, a[5:0]}; end
            else if (a < 16'hD800) begin tag = "R7"; e_sel = 10'd1 << 5; e_idx = {5'h0, a[4:0]}; end
            else if (a < 16'hDC00) begin
                tag = "R8"; e_sel = 10'd1 << 6; e_idx = a[9:0];
                if (wr) e_wr = {4'h0, d[3:0]};
                else begin e_loc = 1'b1; e_rd = {fb[7:4], nb}; end
            end
            else if (a < 16'hDD00) begin tag = "R7"; e_sel = 10'd1 << 7; e_idx = {6'h0, a[3:0]}; end
            else if (a < 16'hDE00) begin tag = "R7"; e_sel = 10'd1 << 8; e_idx = {6'h0, a[3:0]}; end
            else if (a >= 16'hDF00 && a < 16'hDF10) begin tag = "R7"; e_sel = 10'd1 << 9; e_idx = {6'h0, a[3:0]}; end
            else begin
                tag = "R9";
                if (!wr) begin e_loc = 1'b1; e_rd = fb; end
            end
        end else begin
            e_sel = 10'b1;
        end
    endtask

    task automatic check(input string t, input string what, input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic access(input logic en, input logic wr, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] fb, input logic [3:0] nb);
        @(negedge clk);
        bus_en = en; bus_wr = wr; addr = a; wdata = d; float_byte = fb; cram_nib = nb;
        #1;
        expect_calc(en, wr, a, d, fb, nb);
        check(tag, "sel", sel, e_sel);
        check(tag, "reg_idx", reg_idx, e_idx);
        check(tag, "rd_local", {9'h0, rd_local}, {9'h0, e_loc});
        if (e_loc) check(tag, "rd_data", {2'b0, rd_data}, {2'b0, e_rd});
        if (en && wr && e_sel != '0) check(tag, "wr_data", {2'b0, wr_data}, {2'b0, e_wr});
        if (en && wr && a == 16'h0000) m_dir = d;
        if (en && wr && a == 16'h0001) m_dat = d;
    endtask

    function automatic logic [15:0] pick_addr(input int r);
        logic [15:0] v;
        v = 16'($urandom);
        case (r % 8)
            0: v = {15'h0, v[0]};
            1: v = {3'b101, v[12:0]};
            2: v = {3'b111, v[12:0]};
            3, 4: v = {4'hD, v[11:0]};
            5: v = {8'hDF, 4'h0, v[3:0]};
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of the port and the configuration it gives
        access(1, 0, 16'h0000, 8'h00, 8'hAA, 4'h0);
        check("R1", "dir after reset", {2'b0, rd_data}, 10'h000);
        access(1, 0, 16'h0001, 8'h00, 8'hAA, 4'h0);
        check("R1", "port after reset", {2'b0, rd_data}, 10'h017);
        access(1, 0, 16'hA123, 8'h00, 8'hAA, 4'h0);
        check("R1", "basic shown", sel, 10'b10);
        access(1, 0, 16'hD020, 8'h00, 8'hAA, 4'h0);
        check("R1", "io shown", sel, 10'd1 << 4);

        // R11: idle cycle
        access(0, 1, 16'h0000, 8'hFF, 8'h11, 4'h0);
        access(1, 0, 16'h0000, 8'h00, 8'h11, 4'h0);
        check("R11", "idle left dir", {2'b0, rd_data}, 10'h000);

        // Sweep all eight configurations with the direction bits driven
        access(1, 1, 16'h0000, 8'h07, 8'h3C, 4'h0);
        for (int k = 0; k < 8; k++) begin
            access(1, 1, 16'h0001, 8'(k), 8'hC3, 4'h0);
            access(1, 0, 16'h0001, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hA000, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hBFFF, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hE000, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hD000, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hD7FF, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hDBFF, 8'h00, 8'h9E, 4'h5);
            access(1, 1, 16'hD800, 8'hB7, 8'h00, 4'h0);
            access(1, 0, 16'hDC05, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hDD0F, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hDF00, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hDF0F, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hDF10, 8'h00, 8'h6D, 4'h0);
            access(1, 0, 16'hDE00, 8'h00, 8'h42, 4'h0);
            access(1, 1, 16'hDE80, 8'h55, 8'h00, 4'h0);
            access(1, 1, 16'hA000, 8'h99, 8'h00, 4'h0);
            access(1, 1, 16'hFFFF, 8'h98, 8'h00, 4'h0);
            access(1, 1, 16'hD100, 8'h97, 8'h00, 4'h0);
            access(1, 0, 16'h0002, 8'h00, 8'h00, 4'h0);
            access(1, 0, 16'hC7FF, 8'h00, 8'h00, 4'h0);
        end

        // R3: port readback with mixed direction
        access(1, 1, 16'h0000, 8'hA5, 8'h01, 4'h0);
        access(1, 1, 16'h0001, 8'h3C, 8'h02, 4'h0);
        access(1, 0, 16'h0001, 8'h00, 8'h00, 4'h0);
        check("R3", "mixed readback", {2'b0, rd_data}, {2'b0, ((8'hA5 & 8'h3C) | (~8'hA5 & 8'h17))});

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 64);
            access(r != 63, 1'($urandom), pick_addr(int'($urandom)),
                   8'($urandom), 8'($urandom), 4'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule